// File: doc/BRIEF.md
# Page Write-Lock Controller

This block guards writes into a byte-addressed memory zone that is split into 8-byte pages. When the zone runs with write locking switched on, the byte at offset 0 of every page acts as a permission mask for that page. Bit n of this mask decides whether the byte at offset n may be written. Every write command first reads the page's mask in a dedicated memory cycle. The block then decides whether the addressed byte may change and, if it may, stores it. The mask byte can only lose set bits: a write to it stores the bitwise AND of the old and new values. Once its own bit 0 is cleared, the mask byte can no longer be written at all. In locked mode a command stores at most one byte.

When write locking is off for a command, the block accepts up to eight bytes per command. These fill successive offsets of the addressed page, wrapping from offset 7 back to offset 0, and no mask is checked. A host read port reads the same memory while no command is in progress. After each command the block reports, for one cycle, whether the write was refused, whether any bytes were dropped, and how many bytes were stored.

Top module: `pglock_ctrl`

## Requirements
- R1: After reset `busy`, `dat_ready`, `done` and `rd_valid` are 0, and every memory byte reads 0x00.
- R2: A command is taken when `cmd_start` is high while the block is idle. `busy` is high from the next cycle on, and `dat_ready` first goes high in the third cycle after the start is sampled, once the page mask has been fetched.
- R3: In locked mode the page mask is the byte at the address with its low 3 bits cleared. A write to offset n (1 to 7) succeeds only if bit n of the mask is 1.
- R4: A refused write leaves memory unchanged and reports `sts_denied`=1 and `sts_wcount`=0 with that command's `done` pulse.
- R5: In locked mode, a write to offset 0 whose old mask has bit 0 equal to 1 stores old AND new, so no mask bit ever returns from 0 to 1.
- R6: In locked mode, a write to offset 0 is refused whenever bit 0 of the stored mask is 0, even if other mask bits are 1.
- R7: In locked mode only the first data byte of a command is considered. Later bytes are not written and set `sts_dropped`=1.
- R8: With locking off, successive bytes go to successive offsets of the page, wrapping from 7 to 0. Bytes after the eighth are dropped and set `sts_dropped`=1. `sts_wcount` gives the number stored.
- R9: With locking off, the mask byte is ignored and even bytes whose mask bit is 0 are written.
- R10: `done` is a one-cycle pulse in the cycle after the byte marked `dat_last` is accepted. `busy` is low in that same cycle.
- R11: `rd_en` while idle (and with no `cmd_start` in the same cycle) gives `rd_valid`=1 and the byte at `rd_addr` on `rd_data` in the next cycle. `rd_en` while busy is ignored.
- R12: Data bytes presented while `dat_ready` is 0, including one marked `dat_last`, are ignored and neither write memory nor end the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start a write command (taken when idle) |
| cmd_addr | input | ADDR_W | Byte address of the first byte to write |
| cmd_wlock | input | 1 | 1: zone is in write-lock mode for this command |
| busy | output | 1 | A command is in progress |
| dat_valid | input | 1 | A data byte is presented |
| dat_byte | input | 8 | Data byte |
| dat_last | input | 1 | Marks the final byte of the command |
| dat_ready | output | 1 | Data bytes are accepted in this cycle |
| done | output | 1 | One-cycle end-of-command pulse |
| sts_denied | output | 1 | Last command had a refused write |
| sts_dropped | output | 1 | Last command dropped one or more bytes |
| sts_wcount | output | 4 | Bytes stored by the last command |
| rd_en | input | 1 | Host read request |
| rd_addr | input | ADDR_W | Host read address |
| rd_valid | output | 1 | `rd_data` holds the requested byte |
| rd_data | output | 8 | Host read data |

## Verification
The hardest state to reach is a mask byte whose bit 0 is already clear while its other bits stay set. Memory starts at all zeros, so the bench first plants masks with unlocked-mode writes. It then lowers a mask in steps with locked-mode writes to offset 0 and checks the AND result at each step, before trying to write a frozen mask. Bytes offered before the mask fetch completes are also hard to reach. The bench holds `dat_valid` and `dat_last` high through the fetch cycles and then confirms that the command is still open and memory has not changed.

// File: rtl/pglock_pkg.sv
// Shared constants and types for the page write-lock controller.
// Assumes a page is exactly as many bytes as a lock byte has bits.
package pglock_pkg;
    localparam int BYTE_W   = 8;
    localparam int PAGE_B   = BYTE_W;
    localparam int OFF_W    = $clog2(PAGE_B);
    localparam int CNT_W    = OFF_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_LOAD  = 2'd2,
        ST_DATA  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/pglock_mem.sv
// Byte-array storage for the zone: one registered read port, one write port.
// Assumes read and write may hit the same address; the read returns old data.
module pglock_mem
    import pglock_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        // Purpose: hold one byte, cleared at reset, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cells[g] <= '0;
            end else if (we && (waddr == ADDR_W'(g))) begin
                cells[g] <= wdata;
            end
        end
    end

    // Purpose: registered read of the selected byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= cells[raddr];
        end
    end
endmodule

// File: rtl/pglock_judge.sv
// Write decision for one byte: applies the page mask and the one-way rule
// for the mask byte. Purely combinational.
// Assumes lock_byte is the current mask of the page holding the target byte.
module pglock_judge
    import pglock_pkg::*;
(
    input  logic              wlock,
    input  logic [OFF_W-1:0]  offset,
    input  logic [BYTE_W-1:0] lock_byte,
    input  logic [BYTE_W-1:0] new_byte,
    output logic              allow,
    output logic [BYTE_W-1:0] wdata
);
    logic is_mask;

    assign is_mask = (offset == '0);

    // Purpose: choose permission and stored value for the addressed byte.
    always_comb begin
        allow = 1'b1;
        wdata = new_byte;
        if (wlock) begin
            allow = lock_byte[offset];
            if (is_mask) begin
                wdata = lock_byte & new_byte;
            end
        end
    end
endmodule

// File: rtl/pglock_seq.sv
// Command sequencer: fetches the page mask, walks the data bytes, counts
// stored, refused and dropped bytes, and reports at the end of the command.
// Also arbitrates the memory read port between mask fetch and host reads.
// Assumes the judge output refers to the byte presented in the current cycle.
module pglock_seq
    import pglock_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_wlock,
    input  logic              dat_valid,
    input  logic              dat_last,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              jdg_allow,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [OFF_W-1:0]  cur_off,
    output logic [BYTE_W-1:0] cur_lock,
    output logic              cur_wlock,
    output logic              busy,
    output logic              dat_ready,
    output logic              rd_valid,
    output logic              done,
    output logic              sts_denied,
    output logic              sts_dropped,
    output logic [CNT_W-1:0]  sts_wcount
);
    localparam logic [CNT_W-1:0] FULL_PAGE = CNT_W'(PAGE_B);
    localparam logic [CNT_W-1:0] ONE_BYTE  = CNT_W'(1);

    seq_state_t        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              wlock_q;
    logic [BYTE_W-1:0] lock_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              den_q;
    logic              drop_q;
    logic [CNT_W-1:0]  wcnt_q;
    logic              done_q;
    logic              rdv_q;
    logic              sden_q;
    logic              sdrop_q;
    logic [CNT_W-1:0]  swcnt_q;

    logic              host_ok;
    logic [CNT_W-1:0]  limit;
    logic              take;
    logic              accept;
    logic              wr_now;
    logic              den_next;
    logic              drop_next;
    logic [CNT_W-1:0]  wcnt_next;
    logic [ADDR_W-1:0] page_base;

    assign busy      = (state_q != ST_IDLE);
    assign dat_ready = (state_q == ST_DATA);
    assign host_ok   = (state_q == ST_IDLE) && rd_en && !cmd_start;
    assign page_base = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    // Purpose: steer the memory read port to mask fetch or host read.
    always_comb begin
        mem_re    = host_ok;
        mem_raddr = rd_addr;
        if (state_q == ST_FETCH) begin
            mem_re    = 1'b1;
            mem_raddr = page_base;
        end
    end

    // Purpose: locate the current byte in the page and decide if it is taken.
    always_comb begin
        limit     = wlock_q ? ONE_BYTE : FULL_PAGE;
        take      = (cnt_q < limit);
        accept    = dat_ready && dat_valid;
        cur_off   = addr_q[OFF_W-1:0] + cnt_q[OFF_W-1:0];
        mem_waddr = {addr_q[ADDR_W-1:OFF_W], cur_off};
        wr_now    = accept && take && jdg_allow;
        mem_we    = wr_now;
        den_next  = den_q | (take && !jdg_allow);
        drop_next = drop_q | !take;
        wcnt_next = wcnt_q + CNT_W'(wr_now);
    end

    assign cur_lock  = lock_q;
    assign cur_wlock = wlock_q;

    // Purpose: command state machine and per-command tallies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wlock_q <= 1'b0;
            lock_q  <= '0;
            cnt_q   <= '0;
            den_q   <= 1'b0;
            drop_q  <= 1'b0;
            wcnt_q  <= '0;
            done_q  <= 1'b0;
            sden_q  <= 1'b0;
            sdrop_q <= 1'b0;
            swcnt_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cmd_start) begin
                        addr_q  <= cmd_addr;
                        wlock_q <= cmd_wlock;
                        cnt_q   <= '0;
                        den_q   <= 1'b0;
                        drop_q  <= 1'b0;
                        wcnt_q  <= '0;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    state_q <= ST_LOAD;
                end
                ST_LOAD: begin
                    lock_q  <= mem_rdata;
                    state_q <= ST_DATA;
                end
                ST_DATA: begin
                    if (accept) begin
                        if (take) begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                        den_q  <= den_next;
                        drop_q <= drop_next;
                        wcnt_q <= wcnt_next;
                        if (dat_last) begin
                            sden_q  <= den_next;
                            sdrop_q <= drop_next;
                            swcnt_q <= wcnt_next;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: mark host read data as valid one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdv_q <= 1'b0;
        end else begin
            rdv_q <= host_ok;
        end
    end

    assign rd_valid    = rdv_q;
    assign done        = done_q;
    assign sts_denied  = sden_q;
    assign sts_dropped = sdrop_q;
    assign sts_wcount  = swcnt_q;
endmodule

// File: rtl/pglock_ctrl.sv
// Top of the page write-lock controller: sequencer, write judge and zone
// storage. Assumes the caller waits for dat_ready before streaming bytes.
module pglock_ctrl
    import pglock_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_wlock,
    output logic              busy,
    input  logic              dat_valid,
    input  logic [7:0]        dat_byte,
    input  logic              dat_last,
    output logic              dat_ready,
    output logic              done,
    output logic              sts_denied,
    output logic              sts_dropped,
    output logic [3:0]        sts_wcount,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);
    logic              mem_re;
    logic [ADDR_W-1:0] mem_raddr;
    logic [BYTE_W-1:0] mem_rdata;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [BYTE_W-1:0] mem_wdata;
    logic [OFF_W-1:0]  cur_off;
    logic [BYTE_W-1:0] cur_lock;
    logic              cur_wlock;
    logic              jdg_allow;

    pglock_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_start   (cmd_start),
        .cmd_addr    (cmd_addr),
        .cmd_wlock   (cmd_wlock),
        .dat_valid   (dat_valid),
        .dat_last    (dat_last),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .mem_rdata   (mem_rdata),
        .jdg_allow   (jdg_allow),
        .mem_re      (mem_re),
        .mem_raddr   (mem_raddr),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .cur_off     (cur_off),
        .cur_lock    (cur_lock),
        .cur_wlock   (cur_wlock),
        .busy        (busy),
        .dat_ready   (dat_ready),
        .rd_valid    (rd_valid),
        .done        (done),
        .sts_denied  (sts_denied),
        .sts_dropped (sts_dropped),
        .sts_wcount  (sts_wcount)
    );

    pglock_judge u_judge (
        .wlock     (cur_wlock),
        .offset    (cur_off),
        .lock_byte (cur_lock),
        .new_byte  (dat_byte),
        .allow     (jdg_allow),
        .wdata     (mem_wdata)
    );

    pglock_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .re    (mem_re),
        .raddr (mem_raddr),
        .rdata (mem_rdata),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata)
    );

    assign rd_data = mem_rdata;
endmodule

// File: rtl/pglock_ctrl_chk.sv
// Property checker for the page write-lock controller, bound to the top.
// Assumes it sees the top's internal write port and latched command state.
module pglock_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       dat_ready,
    input logic       dat_valid,
    input logic       done,
    input logic       cmd_start,
    input logic       rd_en,
    input logic       rd_valid,
    input logic       sts_denied,
    input logic [3:0] sts_wcount,
    input logic       mem_we,
    input logic [2:0] mem_woff,
    input logic [7:0] mem_wdata,
    input logic [7:0] cur_lock,
    input logic       cur_wlock
);
    assert_fetch_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !dat_ready ##1 !dat_ready ##1 dat_ready);

    assert_mask_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && cur_wlock) |-> cur_lock[mem_woff]);

    assert_denied_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sts_denied && cur_wlock) |-> (sts_wcount == 4'd0));

    assert_mask_oneway_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && cur_wlock && (mem_woff == 3'd0)) |-> ((mem_wdata & ~cur_lock) == 8'h00));

    assert_mask_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && cur_wlock && (mem_woff == 3'd0)) |-> cur_lock[0]);

    assert_single_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cur_wlock) |-> (sts_wcount <= 4'd1));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_host_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(rd_en) && !$past(busy) && !$past(cmd_start)));

    assert_ready_in_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dat_ready |-> busy);

    assert_write_accepted_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (dat_valid && dat_ready));
endmodule

bind pglock_ctrl pglock_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .dat_ready  (dat_ready),
    .dat_valid  (dat_valid),
    .done       (done),
    .cmd_start  (cmd_start),
    .rd_en      (rd_en),
    .rd_valid   (rd_valid),
    .sts_denied (sts_denied),
    .sts_wcount (sts_wcount),
    .mem_we     (mem_we),
    .mem_woff   (mem_waddr[2:0]),
    .mem_wdata  (mem_wdata),
    .cur_lock   (cur_lock),
    .cur_wlock  (cur_wlock)
);

// File: tb/pglock_ctrl_tb.sv
// Directed bench for the page write-lock controller.
module pglock_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start = 1'b0;
    logic [7:0] cmd_addr = '0;
    logic       cmd_wlock = 1'b0;
    logic       busy;
    logic       dat_valid = 1'b0;
    logic [7:0] dat_byte = '0;
    logic       dat_last = 1'b0;
    logic       dat_ready;
    logic       done;
    logic       sts_denied;
    logic       sts_dropped;
    logic [3:0] sts_wcount;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = '0;
    logic       rd_valid;
    logic [7:0] rd_data;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   ended = 1'b0;
    logic [7:0] exp_mem [256];
    logic [7:0] wbuf [16];
    logic       r_den, r_drop;
    logic [3:0] r_wc;

    always #5 clk = ~clk;

    pglock_ctrl #(.ADDR_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .cmd_addr(cmd_addr), .cmd_wlock(cmd_wlock),
        .busy(busy),
        .dat_valid(dat_valid), .dat_byte(dat_byte), .dat_last(dat_last),
        .dat_ready(dat_ready),
        .done(done), .sts_denied(sts_denied), .sts_dropped(sts_dropped),
        .sts_wcount(sts_wcount),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Host read of one byte; compares against the bench's expected memory.
    task automatic read_chk(input logic [7:0] a, input string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check({tag, " rd_valid"}, rd_valid, 1);
        check({tag, " data"}, rd_data, exp_mem[a]);
    endtask

    // Issue one command with n bytes from wbuf; captures status at done.
    task automatic do_write(input logic [7:0] a, input bit wl, input int n);
        int guard;
        @(negedge clk);
        cmd_start = 1'b1; cmd_addr = a; cmd_wlock = wl;
        @(negedge clk);
        cmd_start = 1'b0;
        guard = 0;
        while (!dat_ready && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        for (int i = 0; i < n; i++) begin
            dat_valid = 1'b1; dat_byte = wbuf[i]; dat_last = (i == n - 1);
            @(negedge clk);
        end
        dat_valid = 1'b0; dat_last = 1'b0;
        check("R10 done after last byte", done, 1);
        check("R10 busy low at done", busy, 0);
        r_den = sts_denied; r_drop = sts_dropped; r_wc = sts_wcount;
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 dat_ready", dat_ready, 0);
        check("R1 done", done, 0);
        check("R1 rd_valid", rd_valid, 0);
        read_chk(8'h10, "R1 mem cleared");
        read_chk(8'hF7, "R1 mem cleared hi");
    endtask

    task automatic t_latency();
        @(negedge clk);
        cmd_start = 1'b1; cmd_addr = 8'h08; cmd_wlock = 1'b0;
        @(negedge clk);
        cmd_start = 1'b0;
        check("R2 busy after start", busy, 1);
        check("R2 not ready cycle1", dat_ready, 0);
        @(negedge clk);
        check("R2 not ready cycle2", dat_ready, 0);
        @(negedge clk);
        check("R2 ready cycle3", dat_ready, 1);
        dat_valid = 1'b1; dat_byte = 8'h5C; dat_last = 1'b1;
        @(negedge clk);
        dat_valid = 1'b0; dat_last = 1'b0;
        check("R10 done", done, 1);
        exp_mem[8'h08] = 8'h5C;
        read_chk(8'h08, "R2 byte stored");
    endtask

    task automatic t_plain();
        for (int i = 0; i < 8; i++) wbuf[i] = 8'h11 + 8'(i);
        do_write(8'h20, 1'b0, 8);
        for (int i = 0; i < 8; i++) exp_mem[8'h20 + i] = 8'h11 + 8'(i);
        check("R8 full page count", r_wc, 8);
        check("R8 full page no drop", r_drop, 0);
        read_chk(8'h20, "R8 page byte0");
        read_chk(8'h27, "R8 page byte7");
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3; wbuf[3] = 8'hA4;
        do_write(8'h2D, 1'b0, 4);
        exp_mem[8'h2D] = 8'hA1; exp_mem[8'h2E] = 8'hA2;
        exp_mem[8'h2F] = 8'hA3; exp_mem[8'h28] = 8'hA4;
        check("R8 wrap count", r_wc, 4);
        read_chk(8'h28, "R8 wrap to offset0");
        read_chk(8'h29, "R8 offset1 untouched");
        for (int i = 0; i < 10; i++) wbuf[i] = 8'h30 + 8'(i);
        do_write(8'h30, 1'b0, 10);
        for (int i = 0; i < 8; i++) exp_mem[8'h30 + i] = 8'h30 + 8'(i);
        check("R8 overlong count", r_wc, 8);
        check("R8 overlong dropped", r_drop, 1);
        read_chk(8'h30, "R8 overlong wrap kept first");
        read_chk(8'h38, "R8 next page untouched");
        wbuf[0] = 8'h5A;
        do_write(8'h43, 1'b0, 1);
        exp_mem[8'h43] = 8'h5A;
        check("R9 zero mask ignored", r_den, 0);
        read_chk(8'h43, "R9 written despite mask 0");
    endtask

    task automatic t_gate();
        wbuf[0] = 8'hA5;
        do_write(8'h50, 1'b0, 1);
        exp_mem[8'h50] = 8'hA5;
        wbuf[0] = 8'h22;
        do_write(8'h52, 1'b1, 1);
        exp_mem[8'h52] = 8'h22;
        check("R3 bit2 open", r_den, 0);
        check("R3 bit2 count", r_wc, 1);
        read_chk(8'h52, "R3 open byte stored");
        wbuf[0] = 8'h33;
        do_write(8'h53, 1'b1, 1);
        check("R4 bit3 denied", r_den, 1);
        check("R4 denied count", r_wc, 0);
        read_chk(8'h53, "R4 memory unchanged");
        wbuf[0] = 8'h77;
        do_write(8'h57, 1'b1, 1);
        exp_mem[8'h57] = 8'h77;
        check("R3 bit7 open", r_den, 0);
        read_chk(8'h57, "R3 offset7 stored");
        wbuf[0] = 8'h44;
        do_write(8'h51, 1'b1, 1);
        check("R4 bit1 denied", r_den, 1);
        read_chk(8'h51, "R4 offset1 unchanged");
    endtask

    task automatic t_maskbyte();
        wbuf[0] = 8'hFF;
        do_write(8'h50, 1'b1, 1);
        read_chk(8'h50, "R5 AND with ff keeps a5");
        wbuf[0] = 8'hF3;
        do_write(8'h50, 1'b1, 1);
        exp_mem[8'h50] = 8'hA1;
        check("R5 lower allowed", r_den, 0);
        read_chk(8'h50, "R5 a5 AND f3");
        wbuf[0] = 8'h0E;
        do_write(8'h50, 1'b1, 1);
        exp_mem[8'h50] = 8'h00;
        read_chk(8'h50, "R5 a1 AND 0e");
        wbuf[0] = 8'hFF;
        do_write(8'h50, 1'b1, 1);
        check("R6 cleared mask refuses", r_den, 1);
        read_chk(8'h50, "R6 mask stays 00");
        wbuf[0] = 8'h99;
        do_write(8'h57, 1'b1, 1);
        check("R3 bit7 now closed", r_den, 1);
        read_chk(8'h57, "R3 offset7 kept");
        wbuf[0] = 8'hFE;
        do_write(8'h80, 1'b0, 1);
        exp_mem[8'h80] = 8'hFE;
        wbuf[0] = 8'h00;
        do_write(8'h80, 1'b1, 1);
        check("R6 frozen with other bits set", r_den, 1);
        read_chk(8'h80, "R6 mask fe kept");
        wbuf[0] = 8'h44;
        do_write(8'h81, 1'b1, 1);
        exp_mem[8'h81] = 8'h44;
        check("R6 other bytes still open", r_den, 0);
        read_chk(8'h81, "R6 offset1 stored");
    endtask

    task automatic t_single();
        wbuf[0] = 8'hFF;
        for (int i = 1; i < 8; i++) wbuf[i] = 8'(i);
        do_write(8'h60, 1'b0, 8);
        exp_mem[8'h60] = 8'hFF;
        for (int i = 1; i < 8; i++) exp_mem[8'h60 + i] = 8'(i);
        wbuf[0] = 8'hC2; wbuf[1] = 8'hC3; wbuf[2] = 8'hC4;
        do_write(8'h62, 1'b1, 3);
        exp_mem[8'h62] = 8'hC2;
        check("R7 one stored", r_wc, 1);
        check("R7 extra dropped", r_drop, 1);
        read_chk(8'h62, "R7 first byte");
        read_chk(8'h63, "R7 second ignored");
        read_chk(8'h64, "R7 third ignored");
    endtask

    task automatic t_ready_gate();
        @(negedge clk);
        cmd_start = 1'b1; cmd_addr = 8'h70; cmd_wlock = 1'b0;
        @(negedge clk);
        cmd_start = 1'b0;
        dat_valid = 1'b1; dat_byte = 8'h99; dat_last = 1'b1;
        rd_en = 1'b1; rd_addr = 8'h20;
        @(negedge clk);
        rd_en = 1'b0;
        check("R11 read ignored while busy", rd_valid, 0);
        @(negedge clk);
        dat_valid = 1'b0; dat_last = 1'b0;
        check("R12 command still open", busy, 1);
        check("R12 no done from early last", done, 0);
        check("R12 ready now", dat_ready, 1);
        dat_valid = 1'b1; dat_byte = 8'h11; dat_last = 1'b1;
        @(negedge clk);
        dat_valid = 1'b0; dat_last = 1'b0;
        check("R10 done", done, 1);
        check("R12 count one", sts_wcount, 1);
        @(negedge clk);
        check("R10 done one cycle", done, 0);
        exp_mem[8'h70] = 8'h11;
        read_chk(8'h70, "R12 real byte stored");
        read_chk(8'h71, "R12 early byte not stored");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
        for (int i = 0; i < 16; i++) wbuf[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_plain();
        t_gate();
        t_maskbyte();
        t_single();
        t_ready_gate();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule